// File: doc/BRIEF.md
# Execution Pipe with Issue Buffer

This block is the shared front end and stage pipeline of one functional unit. Work arrives from an upstream issue queue as a valid/ready handshake. It is held in a small per-unit issue buffer and walks through a fixed number of stages. Each finished result then waits in a short writeback buffer until the register file takes it. The arithmetic is out of scope: an ALU operation carries its operand through as the result. Two static inputs choose the operating mode. One lets an instruction skip the issue buffer when the buffer is empty. The other selects pipelined operation, with one instruction per stage, or unpipelined operation, with a single instruction in the whole stage chain.

Loads and stores start a memory access in a set stage and send out a tag with it. Responses may come back in any order, and each one is matched to its waiting instruction by tag. The data check is made only a fixed number of stages later. A memory instruction that reaches that stage without its data stalls there, and everything behind it freezes while the stages ahead keep draining. The configuration inputs are changed only while the unit and both buffers are empty.

Top module: `exec_pipe`

## Requirements
- R1: After reset, iq_ready is 1 and wb_valid and mem_req_valid are 0.
- R2: With bypass enabled, an empty issue buffer and an empty stage chain, an accepted instruction's result is on wb_valid after the 3rd rising edge following the accepting edge.
- R3: With bypass disabled, every instruction spends a cycle in the issue buffer, so its result appears one edge later than in R2 (after the 4th edge following acceptance).
- R4: In pipelined mode, with wb_ready high, instructions accepted on consecutive edges produce writebacks on consecutive cycles.
- R5: In unpipelined mode at most one instruction occupies the stages, so a continuously fed unit delivers results 4 cycles apart.
- R6: iq_kind codes are: 0 ALU, 1 load, 2 store, 3 treated as ALU. Each load or store raises mem_req_valid for exactly one cycle, while it sits in stage 1. The request carries mem_req_addr equal to its operand, mem_req_store set for a store only, and a tag not used by any outstanding request.
- R7: A memory instruction cannot leave stage 2 until the response bearing its tag has arrived, and a response presented in that same cycle is enough. The stages behind it freeze meanwhile. A load's result is the response data. A store's result is its operand, and so is an ALU result.
- R8: Memory responses may return in any order and are matched to their instructions by tag alone.
- R9: The writeback buffer holds 2 results. When it is full and not drained, the last stage holds its instruction. While wb_valid is high and wb_ready is low, wb_id and wb_data stay stable.
- R10: iq_ready is low exactly while the issue buffer holds 4 entries. The bypass is used only when the buffer is empty.
- R11: Results leave in issue order, with none lost and none repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_bypass_en | input | 1 | Allow issue-buffer skip when the buffer is empty |
| cfg_pipelined | input | 1 | 1: one instruction per stage; 0: one instruction in the stage chain |
| iq_valid | input | 1 | Issue queue offers an instruction |
| iq_ready | output | 1 | Unit accepts the offered instruction |
| iq_id | input | 8 | Instruction identifier, returned with the result |
| iq_kind | input | 2 | Operation class (see R6) |
| iq_operand | input | 16 | Operand / memory address |
| mem_req_valid | output | 1 | Memory access start |
| mem_req_tag | output | 2 | Tag of the access |
| mem_req_store | output | 1 | 1 for a store access |
| mem_req_addr | output | 16 | Access address |
| mem_rsp_valid | input | 1 | Memory response present |
| mem_rsp_tag | input | 2 | Tag of the responding access |
| mem_rsp_data | input | 16 | Load data |
| wb_valid | output | 1 | Writeback buffer head valid |
| wb_ready | input | 1 | Register file takes the head |
| wb_id | output | 8 | Identifier of the result |
| wb_data | output | 16 | Result value |

## Verification
The timing is the same for every path. A result enters the writeback buffer on the edge that retires it from stage 2, so it is visible from the following cycle. That is 3 edges after acceptance with the bypass and 4 without. A memory request shows in the cycle after the instruction reaches stage 1, and a response driven in cycle c releases a stalled instruction so that its result shows in cycle c+1. The bench drives inputs at the falling edge, samples 1 ns later, and counts falling edges from the accepting edge. This lets it compare the first wb_valid cycle, the spacing between writebacks and the stall windows against these figures. Every transfer is also compared against a program-order scoreboard filled from the bench's own result function.

// File: rtl/exec_pipe_pkg.sv
package exec_pipe_pkg;

    parameter int ID_W   = 8;
    parameter int DATA_W = 16;
    parameter int TAG_W  = 2;

    typedef enum logic [1:0] {
        OP_ALU   = 2'd0,
        OP_LOAD  = 2'd1,
        OP_STORE = 2'd2
    } op_kind_e;

    typedef struct packed {
        logic [ID_W-1:0]   id;
        op_kind_e          kind;
        logic [DATA_W-1:0] operand;
    } instr_t;

    typedef struct packed {
        logic              vld;
        instr_t            ins;
        logic              req_sent;
        logic              data_ok;
        logic [TAG_W-1:0]  tag;
        logic [DATA_W-1:0] result;
    } stage_t;

    typedef struct packed {
        logic [ID_W-1:0]   id;
        logic [DATA_W-1:0] data;
    } wb_t;

    function automatic logic is_mem(op_kind_e k);
        return (k == OP_LOAD) || (k == OP_STORE);
    endfunction

endpackage

// File: rtl/ep_fifo.sv
module ep_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         full,
    output logic         empty
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PTR_W-1:0]        rd;
        logic [PTR_W-1:0]        wr;
        logic [CNT_W-1:0]        cnt;
    } fifo_st_t;

    fifo_st_t q, d;

    function automatic logic [PTR_W-1:0] bump(logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    always_comb begin
        d     = q;
        head  = q.mem[q.rd];
        full  = (q.cnt == CNT_W'(DEPTH));
        empty = (q.cnt == '0);
        if (push) begin
            d.mem[q.wr] = push_data;
            d.wr        = bump(q.wr);
        end
        if (pop) begin
            d.rd = bump(q.rd);
        end
        if (push && !pop) begin
            d.cnt = q.cnt + CNT_W'(1);
        end else if (pop && !push) begin
            d.cnt = q.cnt - CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    AST_FIFO_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (!full || pop)); // R10
    AST_FIFO_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty); // R11

endmodule

// File: rtl/ep_stages.sv
module ep_stages
    import exec_pipe_pkg::*;
#(
    parameter int STAGES    = 3,
    parameter int MEM_STAGE = 1,
    parameter int MEM_LAT   = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_pipelined,
    input  logic              in_valid,
    input  instr_t            in_ins,
    output logic              in_ready,
    output logic              mem_req_valid,
    output logic [TAG_W-1:0]  mem_req_tag,
    output logic              mem_req_store,
    output logic [DATA_W-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [TAG_W-1:0]  mem_rsp_tag,
    input  logic [DATA_W-1:0] mem_rsp_data,
    output logic              out_valid,
    output wb_t               out_data,
    input  logic              out_accept
);
    localparam int CHK = MEM_STAGE + MEM_LAT;

    typedef struct packed {
        stage_t [STAGES-1:0] stg;
        logic [TAG_W-1:0]    tag_ctr;
    } pipe_st_t;

    pipe_st_t            q, d;
    stage_t              cur [STAGES];
    stage_t              fresh;
    logic [STAGES-1:0]   go;
    logic [STAGES-1:0]   vld_q;
    logic                any_vld;
    logic                fire;
    logic                chk_waiting;
    logic                chk_rsp_hit;

    function automatic logic may_leave(stage_t s, int idx);
        return !(idx == CHK && s.vld && is_mem(s.ins.kind) && !s.data_ok);
    endfunction

    always_comb begin
        d = q;
        for (int i = 0; i < STAGES; i++) begin
            cur[i] = q.stg[i];
        end

        // access start at the memory stage, once per instruction
        mem_req_valid = q.stg[MEM_STAGE].vld && is_mem(q.stg[MEM_STAGE].ins.kind)
                        && !q.stg[MEM_STAGE].req_sent;
        mem_req_tag   = q.tag_ctr;
        mem_req_store = (q.stg[MEM_STAGE].ins.kind == OP_STORE);
        mem_req_addr  = q.stg[MEM_STAGE].ins.operand;
        if (mem_req_valid) begin
            cur[MEM_STAGE].req_sent = 1'b1;
            cur[MEM_STAGE].tag      = q.tag_ctr;
            d.tag_ctr               = q.tag_ctr + TAG_W'(1);
        end

        // response capture by tag in any stage past the access start
        for (int i = MEM_STAGE; i < STAGES; i++) begin
            if (q.stg[i].vld && is_mem(q.stg[i].ins.kind) && q.stg[i].req_sent
                && !q.stg[i].data_ok && mem_rsp_valid && mem_rsp_tag == q.stg[i].tag) begin
                cur[i].data_ok = 1'b1;
                if (q.stg[i].ins.kind == OP_LOAD) begin
                    cur[i].result = mem_rsp_data;
                end
            end
        end

        // advance chain, evaluated from the tail backwards
        go[STAGES-1] = cur[STAGES-1].vld && may_leave(cur[STAGES-1], STAGES-1) && out_accept;
        for (int i = STAGES - 2; i >= 0; i--) begin
            go[i] = cur[i].vld && may_leave(cur[i], i) && (!cur[i+1].vld || go[i+1]);
        end

        any_vld = 1'b0;
        for (int i = 0; i < STAGES; i++) begin
            any_vld = any_vld | q.stg[i].vld;
        end
        in_ready = cfg_pipelined ? (!cur[0].vld || go[0]) : !any_vld;
        fire     = in_valid && in_ready;

        fresh        = '0;
        fresh.vld    = 1'b1;
        fresh.ins    = in_ins;
        fresh.result = in_ins.operand;

        d.stg[0] = fire ? fresh : (go[0] ? '0 : cur[0]);
        for (int i = 1; i < STAGES; i++) begin
            d.stg[i] = go[i-1] ? cur[i-1] : (go[i] ? '0 : cur[i]);
        end

        out_valid = go[STAGES-1];
        out_data  = '{id: cur[STAGES-1].ins.id, data: cur[STAGES-1].result};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        for (int i = 0; i < STAGES; i++) begin
            vld_q[i] = q.stg[i].vld;
        end
        chk_waiting = q.stg[CHK].vld && is_mem(q.stg[CHK].ins.kind) && !q.stg[CHK].data_ok;
        chk_rsp_hit = mem_rsp_valid && (mem_rsp_tag == q.stg[CHK].tag);
    end

    AST_SINGLE_WHEN_UNPIPED: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_pipelined |-> ($countones(vld_q) <= 1)); // R5
    AST_MEM_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_waiting && !chk_rsp_hit) |=> (q.stg[CHK].vld && $stable(q.stg[CHK].ins.id))); // R7
    AST_REQ_NOT_REPEATED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |=> (!mem_req_valid || mem_req_tag != $past(mem_req_tag))); // R6

endmodule

// File: rtl/exec_pipe.sv
module exec_pipe
    import exec_pipe_pkg::*;
#(
    parameter int IB_DEPTH  = 4,
    parameter int WB_DEPTH  = 2,
    parameter int STAGES    = 3,
    parameter int MEM_STAGE = 1,
    parameter int MEM_LAT   = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_bypass_en,
    input  logic              cfg_pipelined,
    input  logic              iq_valid,
    output logic              iq_ready,
    input  logic [ID_W-1:0]   iq_id,
    input  logic [1:0]        iq_kind,
    input  logic [DATA_W-1:0] iq_operand,
    output logic              mem_req_valid,
    output logic [TAG_W-1:0]  mem_req_tag,
    output logic              mem_req_store,
    output logic [DATA_W-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [TAG_W-1:0]  mem_rsp_tag,
    input  logic [DATA_W-1:0] mem_rsp_data,
    output logic              wb_valid,
    input  logic              wb_ready,
    output logic [ID_W-1:0]   wb_id,
    output logic [DATA_W-1:0] wb_data
);
    localparam int INS_W = $bits(instr_t);
    localparam int WB_W  = $bits(wb_t);

    instr_t             iq_ins;
    logic [INS_W-1:0]   ib_head_raw;
    instr_t             ib_head;
    logic               ib_full, ib_empty, ib_push, ib_pop;
    logic               bypass;
    logic               stg_in_valid, stg_in_ready;
    instr_t             stg_in_ins;
    logic               stg_out_valid;
    wb_t                stg_out_data;
    logic               wb_accept, wb_full, wb_empty, wb_pop;
    logic [WB_W-1:0]    wb_head_raw;
    wb_t                wb_head;

    always_comb begin
        iq_ins       = '{id: iq_id, kind: op_kind_e'(iq_kind), operand: iq_operand};
        ib_head      = instr_t'(ib_head_raw);
        wb_head      = wb_t'(wb_head_raw);
        bypass       = cfg_bypass_en && ib_empty && iq_valid && stg_in_ready;
        ib_pop       = !ib_empty && stg_in_ready;
        stg_in_valid = ib_pop || bypass;
        stg_in_ins   = ib_pop ? ib_head : iq_ins;
        iq_ready     = !ib_full;
        ib_push      = iq_valid && !ib_full && !bypass;
        wb_accept    = !wb_full || wb_ready;
        wb_pop       = !wb_empty && wb_ready;
        wb_valid     = !wb_empty;
        wb_id        = wb_head.id;
        wb_data      = wb_head.data;
    end

    ep_fifo #(.W(INS_W), .DEPTH(IB_DEPTH)) u_issue_buf (
        .clk(clk), .rst_n(rst_n),
        .push(ib_push), .push_data(iq_ins), .pop(ib_pop),
        .head(ib_head_raw), .full(ib_full), .empty(ib_empty)
    );

    ep_stages #(.STAGES(STAGES), .MEM_STAGE(MEM_STAGE), .MEM_LAT(MEM_LAT)) u_stages (
        .clk(clk), .rst_n(rst_n), .cfg_pipelined(cfg_pipelined),
        .in_valid(stg_in_valid), .in_ins(stg_in_ins), .in_ready(stg_in_ready),
        .mem_req_valid(mem_req_valid), .mem_req_tag(mem_req_tag),
        .mem_req_store(mem_req_store), .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_tag(mem_rsp_tag), .mem_rsp_data(mem_rsp_data),
        .out_valid(stg_out_valid), .out_data(stg_out_data), .out_accept(wb_accept)
    );

    ep_fifo #(.W(WB_W), .DEPTH(WB_DEPTH)) u_wb_buf (
        .clk(clk), .rst_n(rst_n),
        .push(stg_out_valid), .push_data(stg_out_data), .pop(wb_pop),
        .head(wb_head_raw), .full(wb_full), .empty(wb_empty)
    );

    AST_WB_HELD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid && !wb_ready) |=> (wb_valid && $stable(wb_id) && $stable(wb_data))); // R9
    AST_BYPASS_ONLY_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (iq_valid && iq_ready && !ib_push) |-> (cfg_bypass_en && !ib_pop)); // R10

endmodule

// File: tb/exec_pipe_test.sv
`timescale 1ns/1ps
module exec_pipe_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_bypass_en = 1'b1, cfg_pipelined = 1'b1;
    logic        iq_valid = 1'b0;
    logic        iq_ready;
    logic [7:0]  iq_id = '0;
    logic [1:0]  iq_kind = '0;
    logic [15:0] iq_operand = '0;
    logic        mem_req_valid, mem_req_store;
    logic [1:0]  mem_req_tag;
    logic [15:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [1:0]  mem_rsp_tag = '0;
    logic [15:0] mem_rsp_data = '0;
    logic        wb_valid;
    logic        wb_ready = 1'b0;
    logic [7:0]  wb_id;
    logic [15:0] wb_data;

    always #2.5 clk = ~clk;

    exec_pipe uut (.*);

    int n_chk = 0, n_err = 0, cyc = 0;
    int exp_wr = 0, exp_rd = 0;
    logic [7:0]  exp_id  [0:1023];
    logic [15:0] exp_dat [0:1023];
    int wb_n = 0;
    int wb_cyc [0:63];
    logic [7:0] wb_idlog [0:63];
    int wb_mode = 1;
    bit mem_hold = 0, mem_lifo = 0, mem_rand = 0;
    int req_count = 0, seq_ctr = 0;
    bit pv [8];
    logic [1:0]  pt [8];
    logic [15:0] pa [8];
    bit ps [8];
    int pg [8];
    int pseq [8];

    function automatic logic [15:0] memf(logic [15:0] a);
        return {a[7:0], ~a[15:8]} ^ 16'h3C5A;
    endfunction

    function automatic logic [15:0] exp_result(logic [1:0] k, logic [15:0] op);
        return (k == 2'd1) ? memf(op) : op;
    endfunction

    task automatic check(bit ok, string req, int act, int expv);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, expv, cyc);
        end
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    // environment: memory model, writeback sink, scoreboard
    always @(negedge clk) begin
        #1;
        if (rst_n) begin
            int pick;
            mem_rsp_valid = 1'b0;
            for (int i = 0; i < 8; i++) if (pv[i]) pg[i]++;
            pick = -1;
            if (!mem_hold) begin
                int off;
                off = $urandom % 8;
                for (int j = 0; j < 8; j++) begin
                    int i;
                    i = mem_rand ? (j + off) % 8 : j;
                    if (pv[i] && pg[i] >= 1) begin
                        if (pick < 0) pick = i;
                        else if (!mem_rand && mem_lifo && pseq[i] > pseq[pick]) pick = i;
                        else if (!mem_rand && !mem_lifo && pseq[i] < pseq[pick]) pick = i;
                    end
                end
                if (pick >= 0 && (!mem_rand || ($urandom % 2) == 0)) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_tag   = pt[pick];
                    mem_rsp_data  = ps[pick] ? 16'h0 : memf(pa[pick]);
                    pv[pick]      = 1'b0;
                end
            end
            if (mem_req_valid) begin
                bit dup;
                dup = 0;
                req_count++;
                for (int i = 0; i < 8; i++) if (pv[i] && pt[i] == mem_req_tag) dup = 1;
                check(!dup, "R6 unique tag", mem_req_tag, 0);
                for (int i = 0; i < 8; i++) begin
                    if (!pv[i]) begin
                        pv[i] = 1'b1; pt[i] = mem_req_tag; pa[i] = mem_req_addr;
                        ps[i] = mem_req_store; pg[i] = 0; pseq[i] = seq_ctr++;
                        break;
                    end
                end
            end
            wb_ready = (wb_mode == 2) ? 1'($urandom % 3 != 0) : (wb_mode == 1);
            if (wb_valid && wb_ready) begin
                if (exp_rd == exp_wr) begin
                    check(0, "R11 spurious result", wb_id, 0);
                end else begin
                    check(wb_id == exp_id[exp_rd % 1024], "R11 order", wb_id, exp_id[exp_rd % 1024]);
                    check(wb_data == exp_dat[exp_rd % 1024], "R8 result data", wb_data, exp_dat[exp_rd % 1024]);
                    exp_rd++;
                end
                if (wb_n < 64) begin
                    wb_cyc[wb_n] = cyc; wb_idlog[wb_n] = wb_id;
                end
                wb_n++;
            end
            if (iq_valid && iq_ready) begin
                exp_id[exp_wr % 1024]  = iq_id;
                exp_dat[exp_wr % 1024] = exp_result(iq_kind, iq_operand);
                exp_wr++;
            end
        end
    end

    task automatic issue(logic [7:0] id, logic [1:0] k, logic [15:0] op);
        iq_valid = 1'b1; iq_id = id; iq_kind = k; iq_operand = op;
        while (!iq_ready) @(negedge clk);
        @(negedge clk);
        iq_valid = 1'b0;
    endtask

    task automatic wait_idle();
        int n;
        n = 0;
        while (exp_rd != exp_wr && n < 2000) begin @(negedge clk); n++; end
        repeat (4) @(negedge clk);
        wb_n = 0;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        finish_run();
    end

    initial begin
        int lat;
        int rc;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(iq_ready == 1'b1, "R1 iq_ready", iq_ready, 1);
        check(wb_valid == 1'b0, "R1 wb_valid", wb_valid, 0);
        check(mem_req_valid == 1'b0, "R1 mem_req_valid", mem_req_valid, 0);

        // R2 bypass latency
        wb_mode = 1;
        iq_valid = 1; iq_id = 8'h01; iq_kind = 2'd0; iq_operand = 16'h1111;
        @(negedge clk); iq_valid = 0; lat = 1;
        while (!wb_valid && lat < 50) begin @(negedge clk); lat++; end
        check(lat == 4, "R2 bypass latency", lat, 4);
        wait_idle();

        // R3 no bypass
        cfg_bypass_en = 0;
        iq_valid = 1; iq_id = 8'h02; iq_kind = 2'd3; iq_operand = 16'h2222;
        @(negedge clk); iq_valid = 0; lat = 1;
        while (!wb_valid && lat < 50) begin @(negedge clk); lat++; end
        check(lat == 5, "R3 buffered latency", lat, 5);
        check(wb_data == 16'h2222, "R7 code 3 as ALU", wb_data, 16'h2222);
        wait_idle();
        cfg_bypass_en = 1;

        // R6/R7 load with prompt memory
        rc = req_count;
        iq_valid = 1; iq_id = 8'h03; iq_kind = 2'd1; iq_operand = 16'hBEEF;
        @(negedge clk); iq_valid = 0;
        @(negedge clk);
        check(mem_req_valid == 1 && mem_req_addr == 16'hBEEF && mem_req_store == 0,
              "R6 request in stage 1", {mem_req_valid, mem_req_store}, 2);
        @(negedge clk);
        check(mem_req_valid == 0, "R6 single request", mem_req_valid, 0);
        @(negedge clk);
        check(wb_valid == 1 && wb_data == memf(16'hBEEF), "R7 load no stall", wb_data, memf(16'hBEEF));
        wait_idle();
        check(req_count - rc == 1, "R6 request count", req_count - rc, 1);

        // R7 stall until response, store result
        mem_hold = 1; rc = req_count;
        issue(8'h04, 2'd2, 16'h0440);
        repeat (8) @(negedge clk);
        check(wb_valid == 0, "R7 stalled", wb_valid, 0);
        check(req_count - rc == 1, "R6 once while stalled", req_count - rc, 1);
        mem_hold = 0;
        @(negedge clk);
        check(wb_valid == 1 && wb_data == 16'h0440, "R7 store released", wb_data, 16'h0440);
        wait_idle();

        // R8 out-of-order responses
        mem_hold = 1; mem_lifo = 1;
        issue(8'h0A, 2'd1, 16'h1234);
        issue(8'h0B, 2'd1, 16'h5678);
        repeat (6) @(negedge clk);
        check(wb_valid == 0, "R7 stall behind", wb_valid, 0);
        mem_hold = 0;
        wait_idle();
        mem_lifo = 0;

        // R4 pipelined spacing
        issue(8'h10, 2'd0, 16'h10); issue(8'h11, 2'd0, 16'h11); issue(8'h12, 2'd0, 16'h12);
        repeat (6) @(negedge clk);
        check(wb_cyc[1] - wb_cyc[0] == 1 && wb_cyc[2] - wb_cyc[1] == 1, "R4 back to back",
              wb_cyc[2] - wb_cyc[0], 2);
        wait_idle();

        // R5 unpipelined spacing
        cfg_pipelined = 0;
        issue(8'h20, 2'd0, 16'h20); issue(8'h21, 2'd0, 16'h21); issue(8'h22, 2'd0, 16'h22);
        repeat (14) @(negedge clk);
        check(wb_cyc[1] - wb_cyc[0] == 4, "R5 spacing a", wb_cyc[1] - wb_cyc[0], 4);
        check(wb_cyc[2] - wb_cyc[1] == 4, "R5 spacing b", wb_cyc[2] - wb_cyc[1], 4);
        wait_idle();
        cfg_pipelined = 1;

        // R9/R10 writeback backpressure
        wb_mode = 0;
        for (int i = 0; i < 9; i++) issue(8'h30 + 8'(i), 2'd0, 16'h300 + 16'(i));
        repeat (2) @(negedge clk);
        check(iq_ready == 0, "R10 buffer full", iq_ready, 0);
        check(wb_valid == 1 && wb_id == 8'h30, "R9 head held", wb_id, 8'h30);
        repeat (5) @(negedge clk);
        check(wb_id == 8'h30 && wb_data == 16'h300, "R9 stable", wb_data, 16'h300);
        wb_mode = 1;
        wait_idle();

        // random mix
        wb_mode = 2; mem_rand = 1;
        void'($urandom(32'h5EED));
        for (int b = 0; b < 4; b++) begin
            cfg_bypass_en = b[0]; cfg_pipelined = ~b[1];
            for (int n = 0; n < 80; n++) begin
                repeat ($urandom % 3) @(negedge clk);
                issue(8'(b * 80 + n), 2'($urandom % 4), 16'($urandom));
            end
            wait_idle();
        end
        check(exp_rd == exp_wr, "R11 all retired", exp_rd, exp_wr);
        finish_run();
    end
endmodule